// File: doc/BRIEF.md
# Event-Based Branch Control Unit

This block lets user-level code react to hardware events without a trip through the operating system. It holds three 64-bit registers: an event control and status word, a return-address register and a handler-address register. Two event sources feed it: an external event line and a performance-monitor event line. When an event is enabled and the global enable is on, the block redirects fetch to the handler address. It saves the next-instruction address from the fetch stage so that execution can resume later, and it turns the global enable off.

The handler finishes by issuing the return-from-event-branch instruction. The block decodes this instruction and sends fetch back to the saved return address. A single operand bit of the instruction decides whether the global enable is turned back on. If either of two reserved control bits is set, the return is refused and a program exception for an invalid form is raised. Software reads and writes the three registers through a small select-addressed port.

The control word uses most-significant-first bit numbering, so numbered bit k is bit 63−k of the port vector.

Top module: `ebb_ctrl_unit`

## Requirements
- R1: After reset, all three registers read as zero, and `redirect_o` and `prog_exc_o` are low.
- R2: `sw_sel_i` selects the register, with 0 for the control word, 1 for the return register and 2 for the handler register. A write takes effect at the clock edge. The read data is combinational, and select 3 reads zero.
- R3: A taken event clears the global enable (numbered bit 0, vector bit 63) at the next edge. It also sets the occurred flag of each source that fired: external at numbered bit 62 (vector bit 1) and monitor at numbered bit 63 (vector bit 0).
- R4: In the cycle an event is taken, `redirect_o` is high and `redirect_pc_o` equals the handler register. At the edge, the return register is loaded with `nia_i` with its low two bits forced to zero.
- R5: The return instruction matches when `insn_valid_i` is high, bits 31:26 equal 010011 and bits 10:1 equal 0010010010. Bits 25:12 and bit 0 are ignored. When it executes it redirects to the return register, and at the edge the global enable takes the value of S (instruction bit 11).
- R6: The reserved control bits are numbered 32 and 33 (vector bits 31 and 30). If either is set, a return raises `prog_exc_o` instead of redirecting and leaves the control word unchanged.
- R7: An event is taken only when the global enable is 1, the source's enable is 1 and that source's pulse arrives. The external enable is numbered bit 30 (vector 33) and the monitor enable is numbered bit 31 (vector 32). A pulse from a disabled source has no lasting effect.
- R8: The low two bits of the return and handler registers always read zero, whatever value is written to them.
- R9: When both enabled sources fire in the same cycle, both occurred flags are set and exactly one redirect is issued.
- R10: An enabled event that arrives while the global enable is 0 stays pending, without setting its flag. It is taken in the first cycle after software or a return sets the global enable.
- R11: An occurred flag stays set until software writes the control word.
- R12: A word that differs from the return encoding in any decoded bit causes no redirect and no exception.
- R13: A return instruction in the same cycle as an event wins. The event stays pending and is taken in the following cycle if the enable is then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_evt_i | input | 1 | External event pulse |
| pm_evt_i | input | 1 | Performance-monitor event pulse |
| nia_i | input | 64 | Address of the next instruction to execute |
| insn_valid_i | input | 1 | Instruction word is executing this cycle |
| insn_i | input | 32 | Instruction word |
| sw_we_i | input | 1 | Software register write strobe |
| sw_sel_i | input | 2 | Register select |
| sw_wdata_i | input | 64 | Software write data |
| sw_rdata_o | output | 64 | Software read data |
| redirect_o | output | 1 | Fetch redirect request |
| redirect_pc_o | output | 64 | Redirect target address |
| prog_exc_o | output | 1 | Invalid-form program exception |

## Verification
Internal state faults surface at the ports within one or two cycles. A lost pending bit shows up as a missing redirect in the first cycle after the enable is set again. A global enable that was not cleared shows up as a second redirect one cycle after entry. A wrong saved address appears as soon as the return register is read or a return is executed. Sweeping every combination of enables and pulses exposes the gating, and sweeping every combination of S and the reserved bits exposes the return path. Flipping each instruction bit one at a time covers the decode.

// File: rtl/ebb_pkg.sv
package ebb_pkg;
   localparam int CTRL_W = 64;

   // Convert a most-significant-first bit number into a vector index.
   function automatic int msb_first(input int k);
      return CTRL_W - 1 - k;
   endfunction

   localparam int GE_POS    = msb_first(0);
   localparam int EXT_EN    = msb_first(30);
   localparam int PM_EN     = msb_first(31);
   localparam int RSV_HI    = msb_first(32);
   localparam int RSV_LO    = msb_first(33);
   localparam int EXT_OCC   = msb_first(62);
   localparam int PM_OCC    = msb_first(63);

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_RET  = 2'd1,
      SEL_HDL  = 2'd2,
      SEL_NONE = 2'd3
   } ebb_sel_e;

   // Source 0 is the external line, source 1 the performance monitor.
   function automatic int en_pos(input int src);
      return (src == 0) ? EXT_EN : PM_EN;
   endfunction

   function automatic int occ_pos(input int src);
      return (src == 0) ? EXT_OCC : PM_OCC;
   endfunction

   localparam logic [31:0] RET_MASK  = {6'h3F, 14'h0, 1'b0, 10'h3FF, 1'b0};
   localparam logic [31:0] RET_MATCH = {6'b010011, 14'h0, 1'b0, 10'b0010010010, 1'b0};
   localparam int          RET_S_BIT = 11;
endpackage

// File: rtl/ebb_ret_decode.sv
module ebb_ret_decode
   import ebb_pkg::*;
#(
   parameter int ILEN = 32
) (
   input  logic            valid,
   input  logic [ILEN-1:0] insn,
   output logic            is_ret,
   output logic            s_bit
);
   generate
      if (ILEN != 32) begin : g_bad_ilen
         $error("ebb_ret_decode: ILEN must be 32");
      end
   endgenerate

   always_comb begin
      is_ret = valid && ((insn & RET_MASK) == RET_MATCH);
      s_bit  = insn[RET_S_BIT];
   end
endmodule

// File: rtl/ebb_event_arb.sv
module ebb_event_arb #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ge,
   input  logic            hold,
   input  logic [NSRC-1:0] src_en,
   input  logic [NSRC-1:0] pulse,
   output logic            take,
   output logic [NSRC-1:0] fired
);
   generate
      if (NSRC < 1) begin : g_bad_nsrc
         $error("ebb_event_arb: NSRC must be at least 1");
      end
   endgenerate

   logic [NSRC-1:0] pend_q;
   logic [NSRC-1:0] cand;

   always_comb begin
      cand  = src_en & (pulse | pend_q);
      take  = ge && !hold && (|cand);
      fired = take ? cand : '0;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NSRC; gi++) begin : g_src
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pend_q[gi] <= 1'b0;
            else if (fired[gi])
               pend_q[gi] <= 1'b0;
            else if (pulse[gi] && src_en[gi])
               pend_q[gi] <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/ebb_regs.sv
module ebb_regs
   import ebb_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int ALIGN = 2,
   parameter int NSRC  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we,
   input  ebb_sel_e         sw_sel,
   input  logic [XLEN-1:0]  sw_wdata,
   input  logic             entry,
   input  logic [NSRC-1:0]  fired,
   input  logic [XLEN-1:ALIGN] nia_hi,
   input  logic             ret_ok,
   input  logic             ret_s,
   output logic [XLEN-1:0]  ctrl,
   output logic [XLEN-1:0]  ret_addr,
   output logic [XLEN-1:0]  hdl_addr
);
   generate
      if (XLEN != CTRL_W) begin : g_bad_xlen
         $error("ebb_regs: XLEN must equal CTRL_W");
      end
      if (ALIGN < 1 || ALIGN >= XLEN) begin : g_bad_align
         $error("ebb_regs: ALIGN out of range");
      end
   endgenerate

   localparam int HI_W = XLEN - ALIGN;

   logic [XLEN-1:0] ctrl_q, ctrl_d;
   logic [HI_W-1:0] ret_q, hdl_q;

   always_comb begin
      ctrl_d = ctrl_q;
      if (sw_we && sw_sel == SEL_CTRL)
         ctrl_d = sw_wdata;
      if (ret_ok)
         ctrl_d[GE_POS] = ret_s;
      if (entry) begin
         ctrl_d[GE_POS] = 1'b0;
         for (int i = 0; i < NSRC; i++)
            if (fired[i])
               ctrl_d[occ_pos(i)] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         ret_q  <= '0;
         hdl_q  <= '0;
      end else begin
         ctrl_q <= ctrl_d;
         if (entry)
            ret_q <= nia_hi;
         else if (sw_we && sw_sel == SEL_RET)
            ret_q <= sw_wdata[XLEN-1:ALIGN];
         if (sw_we && sw_sel == SEL_HDL)
            hdl_q <= sw_wdata[XLEN-1:ALIGN];
      end
   end

   assign ctrl     = ctrl_q;
   assign ret_addr = {ret_q, {ALIGN{1'b0}}};
   assign hdl_addr = {hdl_q, {ALIGN{1'b0}}};
endmodule

// File: rtl/ebb_ctrl_unit.sv
module ebb_ctrl_unit
   import ebb_pkg::*;
#(
   parameter int XLEN  = 64,
   parameter int ILEN  = 32,
   parameter int ALIGN = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ext_evt_i,
   input  logic            pm_evt_i,
   input  logic [XLEN-1:0] nia_i,
   input  logic            insn_valid_i,
   input  logic [ILEN-1:0] insn_i,
   input  logic            sw_we_i,
   input  logic [1:0]      sw_sel_i,
   input  logic [XLEN-1:0] sw_wdata_i,
   output logic [XLEN-1:0] sw_rdata_o,
   output logic            redirect_o,
   output logic [XLEN-1:0] redirect_pc_o,
   output logic            prog_exc_o
);
   localparam int NSRC = 2;

   ebb_sel_e        sel;
   logic            is_ret, ret_s, ret_ok, rsv_bad;
   logic            evt_take;
   logic [NSRC-1:0] fired, src_en, pulses;
   logic [XLEN-1:0] ctrl_q, ret_addr, hdl_addr;

   assign sel = ebb_sel_e'(sw_sel_i);

   ebb_ret_decode #(.ILEN(ILEN)) u_dec (
      .valid  (insn_valid_i),
      .insn   (insn_i),
      .is_ret (is_ret),
      .s_bit  (ret_s)
   );

   always_comb begin
      rsv_bad = |ctrl_q[RSV_HI:RSV_LO];
      ret_ok  = is_ret && !rsv_bad;
      for (int i = 0; i < NSRC; i++)
         src_en[i] = ctrl_q[en_pos(i)];
      pulses = {pm_evt_i, ext_evt_i};
   end

   ebb_event_arb #(.NSRC(NSRC)) u_arb (
      .clk    (clk),
      .rst_n  (rst_n),
      .ge     (ctrl_q[GE_POS]),
      .hold   (is_ret),
      .src_en (src_en),
      .pulse  (pulses),
      .take   (evt_take),
      .fired  (fired)
   );

   ebb_regs #(.XLEN(XLEN), .ALIGN(ALIGN), .NSRC(NSRC)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_we    (sw_we_i),
      .sw_sel   (sel),
      .sw_wdata (sw_wdata_i),
      .entry    (evt_take),
      .fired    (fired),
      .nia_hi   (nia_i[XLEN-1:ALIGN]),
      .ret_ok   (ret_ok),
      .ret_s    (ret_s),
      .ctrl     (ctrl_q),
      .ret_addr (ret_addr),
      .hdl_addr (hdl_addr)
   );

   always_comb begin
      case (sel)
         SEL_CTRL: sw_rdata_o = ctrl_q;
         SEL_RET:  sw_rdata_o = ret_addr;
         SEL_HDL:  sw_rdata_o = hdl_addr;
         default:  sw_rdata_o = '0;
      endcase
      redirect_o    = evt_take || ret_ok;
      redirect_pc_o = ret_ok ? ret_addr : hdl_addr;
      prog_exc_o    = is_ret && rsv_bad;
   end
endmodule

// File: rtl/ebb_ctrl_unit_chk.sv
module ebb_ctrl_unit_chk
   import ebb_pkg::*;
#(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            take,
   input logic            ret_ok,
   input logic            ret_s,
   input logic [XLEN-1:0] ctrl,
   input logic [XLEN-1:0] ret_addr,
   input logic [XLEN-1:0] nia,
   input logic            redirect,
   input logic [XLEN-1:0] redirect_pc,
   input logic            prog_exc,
   input logic            sw_we,
   input logic [1:0]      sw_sel
);
   localparam logic [XLEN-1:0] LOW_CLR = ~XLEN'(3);

   p_ge_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !ctrl[GE_POS]);

   p_ret_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> ret_addr == ($past(nia) & LOW_CLR));

   p_ret_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ret_ok |-> (redirect && redirect_pc == ret_addr));

   p_ret_ge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ret_ok |=> ctrl[GE_POS] == $past(ret_s));

   p_exc_no_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
      prog_exc |-> !redirect);

   p_gate_ge_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> ctrl[GE_POS]);

   p_occ_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[EXT_OCC] && !(sw_we && sw_sel == 2'd0)) |=> ctrl[EXT_OCC]);

   p_ret_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_ok || prog_exc) |-> !take);
endmodule

bind ebb_ctrl_unit ebb_ctrl_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .take        (evt_take),
   .ret_ok      (ret_ok),
   .ret_s       (ret_s),
   .ctrl        (ctrl_q),
   .ret_addr    (ret_addr),
   .nia         (nia_i),
   .redirect    (redirect_o),
   .redirect_pc (redirect_pc_o),
   .prog_exc    (prog_exc_o),
   .sw_we       (sw_we_i),
   .sw_sel      (sw_sel_i)
);

// File: tb/ebb_ctrl_unit_tb.sv
`timescale 1ns/1ps
module ebb_ctrl_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_evt = 1'b0, pm_evt = 1'b0;
   logic [63:0] nia = '0;
   logic        insn_valid = 1'b0;
   logic [31:0] insn = '0;
   logic        sw_we = 1'b0;
   logic [1:0]  sw_sel = 2'd0;
   logic [63:0] sw_wdata = '0;
   logic [63:0] sw_rdata, redirect_pc;
   logic        redirect, prog_exc;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   localparam logic [63:0] HDL = 64'h0000_0000_0040_1000;
   localparam logic [63:0] RET = 64'h0000_0000_7000_2468;
   localparam logic [63:0] NIA = 64'h0123_4567_89AB_CDEF;

   always #10 clk = ~clk;

   ebb_ctrl_unit dut_i (
      .clk(clk), .rst_n(rst_n), .ext_evt_i(ext_evt), .pm_evt_i(pm_evt),
      .nia_i(nia), .insn_valid_i(insn_valid), .insn_i(insn),
      .sw_we_i(sw_we), .sw_sel_i(sw_sel), .sw_wdata_i(sw_wdata),
      .sw_rdata_o(sw_rdata), .redirect_o(redirect),
      .redirect_pc_o(redirect_pc), .prog_exc_o(prog_exc)
   );

   function automatic logic [63:0] mk(bit g, bit ee, bit pme);
      logic [63:0] v = '0;
      v[63] = g; v[33] = ee; v[32] = pme;
      return v;
   endfunction

   function automatic logic [31:0] ret_insn(bit s);
      return {6'b010011, 14'h0, s, 10'b0010010010, 1'b0};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; step(); step(); rst_n = 1'b1;
   endtask

   task automatic wr(input logic [1:0] sel, input logic [63:0] d);
      sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
      step();
      sw_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [63:0] d);
      sw_sel = sel; #1; d = sw_rdata;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] v, e;
      @(negedge clk);
      do_reset();

      // R1: reset state
      rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
      rd(2'd1, v); chk(v == 0, "R1 ret", v, 0);
      rd(2'd2, v); chk(v == 0, "R1 hdl", v, 0);
      chk(!redirect && !prog_exc, "R1 outputs", {redirect, prog_exc}, 0);

      // R2, R8: select and alignment
      wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(2'd2, 64'h1234_5678_9ABC_DEF3);
      rd(2'd1, v); chk(v == 64'hFFFF_FFFF_FFFF_FFFC, "R8 ret align", v, 64'hFFFF_FFFF_FFFF_FFFC);
      rd(2'd2, v); chk(v == 64'h1234_5678_9ABC_DEF0, "R8 hdl align", v, 64'h1234_5678_9ABC_DEF0);
      rd(2'd3, v); chk(v == 0, "R2 unused select", v, 0);

      // R3 R4 R7 R9 R10: sweep enables and pulses
      for (int c = 0; c < 32; c++) begin
         bit g, ee, pme, ex, pm, tk, pend;
         g = c[0]; ee = c[1]; pme = c[2]; ex = c[3]; pm = c[4];
         do_reset();
         wr(2'd2, HDL);
         wr(2'd0, mk(g, ee, pme));
         ext_evt = ex; pm_evt = pm; nia = NIA; #1;
         pend = (ee && ex) || (pme && pm);
         tk = g && pend;
         chk(redirect == tk, "R7 take gating", redirect, tk);
         if (tk) chk(redirect_pc == HDL, "R4 handler target", redirect_pc, HDL);
         step();
         ext_evt = 1'b0; pm_evt = 1'b0;
         e = mk(tk ? 1'b0 : g, ee, pme);
         e[1] = tk && ee && ex; e[0] = tk && pme && pm;
         rd(2'd0, v); chk(v == e, "R3 R9 ctrl after event", v, e);
         if (tk) begin
            rd(2'd1, v);
            chk(v == (NIA & ~64'h3), "R4 saved return", v, NIA & ~64'h3);
         end
         chk(redirect == 1'b0, "R9 single redirect", redirect, 0);
         if (!g) begin
            wr(2'd0, mk(1'b1, ee, pme)); #1;
            chk(redirect == pend, "R10 pending taken after enable", redirect, pend);
            step();
            e = mk(pend ? 1'b0 : 1'b1, ee, pme);
            e[1] = pend && ee && ex; e[0] = pend && pme && pm;
            rd(2'd0, v); chk(v == e, "R10 ctrl after pending", v, e);
         end
      end

      // R5 R6: return with S and reserved bits
      for (int c = 0; c < 16; c++) begin
         bit s, r32, r33, g, ok;
         logic [63:0] init;
         s = c[0]; r32 = c[1]; r33 = c[2]; g = c[3];
         ok = !(r32 || r33);
         do_reset();
         wr(2'd1, RET);
         init = mk(g, 1'b0, 1'b0); init[31] = r32; init[30] = r33;
         wr(2'd0, init);
         insn = ret_insn(s); insn_valid = 1'b1; #1;
         chk(redirect == ok, "R5 R6 return redirect", redirect, ok);
         chk(prog_exc == !ok, "R6 exception", prog_exc, !ok);
         if (ok) chk(redirect_pc == RET, "R5 return target", redirect_pc, RET);
         step();
         insn_valid = 1'b0;
         e = init; if (ok) e[63] = s;
         rd(2'd0, v); chk(v == e, "R5 R6 ctrl after return", v, e);
      end

      // R12: single-bit flips of the encoding
      do_reset();
      wr(2'd1, RET);
      for (int b = 0; b < 32; b++) begin
         bit m;
         m = !(b >= 26 || (b >= 1 && b <= 10));
         insn = ret_insn(1'b0) ^ (32'h1 << b); insn_valid = 1'b1; #1;
         chk(redirect == m, "R12 decode bit flip", redirect, m);
         chk(prog_exc == 1'b0, "R12 no exception", prog_exc, 0);
         insn_valid = 1'b0; #1;
      end
      insn = ret_insn(1'b1); #1;
      chk(redirect == 1'b0, "R12 invalid slot ignored", redirect, 0);

      // R13 R11: return beats event, event deferred
      do_reset();
      wr(2'd2, HDL);
      wr(2'd1, RET);
      wr(2'd0, mk(1'b1, 1'b1, 1'b0));
      ext_evt = 1'b1; insn = ret_insn(1'b1); insn_valid = 1'b1; nia = NIA; #1;
      chk(redirect_pc == RET, "R13 return wins", redirect_pc, RET);
      step();
      ext_evt = 1'b0; insn_valid = 1'b0;
      rd(2'd0, v); chk(v == mk(1'b1, 1'b1, 1'b0), "R13 no flag yet", v, mk(1'b1, 1'b1, 1'b0));
      chk(redirect && redirect_pc == HDL, "R13 deferred event", redirect_pc, HDL);
      step();
      e = mk(1'b0, 1'b1, 1'b0); e[1] = 1'b1;
      rd(2'd0, v); chk(v == e, "R13 flag after deferred", v, e);
      step(); step();
      rd(2'd0, v); chk(v[1] == 1'b1, "R11 flag sticky", v, e);
      wr(2'd0, mk(1'b0, 1'b1, 1'b0));
      rd(2'd0, v); chk(v[1] == 1'b0, "R11 software clears", v, mk(1'b0, 1'b1, 1'b0));

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule